// File: doc/BRIEF.md
# Split Fetch/Data Bank Extender

This block widens the 16-bit address of an 8-bit processor to a 24-bit physical address. The upper byte comes from one of two 8-bit bank registers. A cycle flagged as an opcode fetch uses the code bank register. Every other read or write uses the data bank register. Code and data can therefore sit in different 64 KiB banks, and software can move its data window without leaving the bank that holds its running code.

The low 16 bits of the processor address pass through to the physical bus unchanged. Both bank registers sit at a pair of adjacent I/O addresses set by a parameter, and the processor writes and reads them back over its 8-bit data bus. A register write takes effect on the next bus cycle. The physical address driven during the writing cycle still uses the old bank value.

Top module: `bank_ext`

## Requirements
- R1: After reset, both bank registers hold zero, so every physical address has upper byte 0x00 and both readbacks return 0x00.
- R2: Physical address bits 15..0 always equal the processor address bits 15..0.
- R3: When `cpu_sync` is high, physical address bits 23..16 equal the code bank register.
- R4: When `cpu_sync` is low, physical address bits 23..16 equal the data bank register.
- R5: A write cycle (`bus_en`=1, `cpu_rd`=0) to `REG_BASE` (address bit 0 = 0) loads `cpu_wdata` into the code bank. A write cycle to `REG_BASE`+1 (address bit 0 = 1) loads `cpu_wdata` into the data bank.
- R6: A bank write changes the physical address only from the next bus cycle on. The cycle that performs the write still uses the previous bank value.
- R7: A read cycle (`bus_en`=1, `cpu_rd`=1) to `REG_BASE` or `REG_BASE`+1 raises `reg_rd_en` and returns the code bank or the data bank, respectively, on `reg_rdata` in the same cycle. `reg_rd_en` stays low for every other address.
- R8: Neither bank changes on a write to any other address, on any cycle with `bus_en` low, or on a read of the register addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one bus cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Current cycle is a valid bus access |
| cpu_addr | input | 16 | Processor address |
| cpu_sync | input | 1 | High during an opcode fetch cycle |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | Processor write data |
| phys_addr | output | 24 | Physical address: bank byte above the processor address |
| reg_rdata | output | 8 | Readback value of the selected bank register |
| reg_rd_en | output | 1 | High when `reg_rdata` should drive the data bus |

## Verification
The physical address and the readback path are combinational, so their results are due in the same cycle as the inputs that select them. The bench drives each cycle just after the falling edge and samples one nanosecond later, before the next rising edge. A bank write lands on the rising edge that closes its cycle. The bench therefore checks the old bank during the writing cycle and the new bank on the following cycle, against a model updated at that same boundary. The sweep writes all 256 values into each bank and places ignored writes between readbacks.

// File: rtl/bank_ext.sv
module bank_ext #(
  parameter int CPU_AW = 16,
  parameter int BANK_W = 8,
  parameter logic [CPU_AW-1:0] REG_BASE = 16'hFE00
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_en,
  input  logic [CPU_AW-1:0]        cpu_addr,
  input  logic                     cpu_sync,
  input  logic                     cpu_rd,
  input  logic [BANK_W-1:0]        cpu_wdata,
  output logic [CPU_AW+BANK_W-1:0] phys_addr,
  output logic [BANK_W-1:0]        reg_rdata,
  output logic                     reg_rd_en
);

  logic [BANK_W-1:0] code_bank;
  logic [BANK_W-1:0] data_bank;

  wire reg_hit = cpu_addr[CPU_AW-1:1] == REG_BASE[CPU_AW-1:1];
  wire reg_wr  = bus_en & ~cpu_rd & reg_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_bank <= '0;
      data_bank <= '0;
    end else if (reg_wr) begin
      if (cpu_addr[0]) data_bank <= cpu_wdata;
      else             code_bank <= cpu_wdata;
    end
  end

  assign phys_addr = {(cpu_sync ? code_bank : data_bank), cpu_addr};
  assign reg_rd_en = bus_en & cpu_rd & reg_hit;
  assign reg_rdata = reg_rd_en ? (cpu_addr[0] ? data_bank : code_bank) : '0;

endmodule

// File: rtl/bank_ext_chk.sv
module bank_ext_chk #(
  parameter int CPU_AW = 16,
  parameter int BANK_W = 8,
  parameter logic [CPU_AW-1:0] REG_BASE = 16'hFE00
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_en,
  input logic [CPU_AW-1:0]        cpu_addr,
  input logic                     cpu_sync,
  input logic                     cpu_rd,
  input logic [BANK_W-1:0]        cpu_wdata,
  input logic [BANK_W-1:0]        code_bank,
  input logic [BANK_W-1:0]        data_bank,
  input logic [CPU_AW+BANK_W-1:0] phys_addr
);
  localparam int PW = CPU_AW + BANK_W;

  wire hit = cpu_addr[CPU_AW-1:1] == REG_BASE[CPU_AW-1:1];
  wire wr  = bus_en && !cpu_rd && hit;

  // R1
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (code_bank == '0 && data_bank == '0));

  // R3
  fetch_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sync |-> phys_addr[PW-1:CPU_AW] == code_bank);

  // R4
  data_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_sync |-> phys_addr[PW-1:CPU_AW] == data_bank);

  // R5
  code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && !cpu_addr[0]) |-> code_bank == $past(cpu_wdata));

  // R5
  data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr && cpu_addr[0]) |-> data_bank == $past(cpu_wdata));

  // R8
  hold_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr) |-> ($stable(code_bank) && $stable(data_bank)));
endmodule

bind bank_ext bank_ext_chk #(.CPU_AW(CPU_AW), .BANK_W(BANK_W), .REG_BASE(REG_BASE)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .cpu_addr(cpu_addr),
  .cpu_sync(cpu_sync), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
  .code_bank(code_bank), .data_bank(data_bank), .phys_addr(phys_addr)
);

// File: tb/bank_ext_tb_top.sv
`timescale 1ns/1ps
module bank_ext_tb_top;
  localparam logic [15:0] BASE = 16'hFE00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_sync = 1'b0;
  logic        cpu_rd = 1'b1;
  logic [7:0]  cpu_wdata = '0;
  logic [23:0] phys_addr;
  logic [7:0]  reg_rdata;
  logic        reg_rd_en;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_code = '0;
  logic [7:0] m_data = '0;

  always #2.5 clk = ~clk;

  bank_ext #(.CPU_AW(16), .BANK_W(8), .REG_BASE(BASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .cpu_addr(cpu_addr),
    .cpu_sync(cpu_sync), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .phys_addr(phys_addr), .reg_rdata(reg_rdata), .reg_rd_en(reg_rd_en)
  );

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic bus(logic en, logic sync, logic rd, logic [15:0] a, logic [7:0] wd);
    @(negedge clk);
    bus_en = en; cpu_sync = sync; cpu_rd = rd; cpu_addr = a; cpu_wdata = wd;
    #1;
  endtask

  task automatic readback();
    bus(1, 0, 1, BASE, 8'h00);
    check("R7 code readback", {15'd0, reg_rd_en, reg_rdata}, {15'd0, 1'b1, m_code});
    bus(1, 0, 1, BASE + 16'd1, 8'h00);
    check("R7 data readback", {15'd0, reg_rd_en, reg_rdata}, {15'd0, 1'b1, m_data});
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cpu_addr = 16'h4321; cpu_sync = 1'b1;
    #1 check("R1 fetch bank at reset", phys_addr, 24'h004321);
    cpu_sync = 1'b0;
    #1 check("R1 data bank at reset", phys_addr, 24'h004321);
    @(negedge clk);
    rst_n = 1'b1;
    readback();

    for (int v = 0; v < 256; v++) begin
      logic [15:0] a;
      a = 16'(v * 257) ^ 16'h1234;
      // R5 R6: code bank write, cycle itself uses the old data bank
      bus(1, 0, 0, BASE, 8'(v));
      check("R6 old bank on write cycle", phys_addr, {m_data, BASE});
      m_code = 8'(v);
      bus(1, 0, 0, BASE + 16'd1, ~8'(v));
      check("R6 old bank on write cycle", phys_addr, {m_data, BASE + 16'd1});
      m_data = ~8'(v);
      bus(1, 1, 1, a, 8'h00);
      check("R3 R2 fetch uses code bank", phys_addr, {m_code, a});
      bus(1, 0, 1, ~a, 8'h00);
      check("R4 R2 data uses data bank", phys_addr, {m_data, ~a});
      bus(1, 0, 0, a, 8'h33);
      check("R4 data write uses data bank", phys_addr, {m_data, a});
      if (a[15:1] != BASE[15:1])
        check("R7 no rd_en off window", {23'd0, reg_rd_en}, 24'd0);
      if (v % 16 == 0) begin
        // R8: ignored writes
        bus(1, 0, 0, BASE + 16'd2, 8'h5A);
        bus(1, 0, 0, BASE - 16'd1, 8'hC3);
        bus(0, 0, 0, BASE, 8'hA5);
        bus(0, 0, 0, BASE + 16'd1, 8'hA5);
        bus(1, 0, 1, BASE, 8'h77);
        bus(1, 1, 1, 16'h0000, 8'h00);
        check("R8 code bank untouched", phys_addr, {m_code, 16'h0000});
        bus(1, 0, 1, 16'hFFFF, 8'h00);
        check("R8 data bank untouched", phys_addr, {m_data, 16'hFFFF});
        bus(1, 0, 1, BASE + 16'd2, 8'h00);
        check("R7 no rd_en next to window", {23'd0, reg_rd_en}, 24'd0);
        readback();
      end
    end

    // R6: write then immediate fetch in the very next cycle
    bus(1, 0, 0, BASE, 8'hC7);
    m_code = 8'hC7;
    bus(1, 1, 1, 16'h8000, 8'h00);
    check("R6 new code bank next cycle", phys_addr, 24'hC78000);
    readback();

    @(negedge clk);
    bus_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule